// File: doc/BRIEF.md
# Quaternary Digit-Parallel Logic and Arithmetic Unit

This block operates on a vector of four-valued digits, every digit held as a two-bit pair, and produces one result vector of the same width. A four-bit operation code picks the function. Seven codes apply a conventional gate to the two bits of each pair independently. Two further codes compute modulo-4 sum and modulo-4 product per digit. These two use dedicated XOR/AND equations, because a plain bit-wise XOR or AND of two pairs yields neither.

Every digit lane stands alone: no carry, borrow or overflow leaves a lane and none enters one. The lane count is a parameter. A second parameter inserts an output register with synchronous active-low reset, giving one cycle of latency; without it the path is purely combinational.

Top module: `quad_lane_alu`

## Requirements
- R1: A digit of value v in 0..3 is carried as the pair v[1:0] (00, 01, 10, 11), and lane k occupies bits [2k+1:2k] of each operand and of the result.
- R2: Code 0 gives bit-wise OR, code 1 bit-wise AND and code 3 bit-wise XOR of the two operand pairs, per lane.
- R3: Code 2 gives the bit-wise inverse of operand A, and operand B has no effect on the result.
- R4: Code 4 gives bit-wise NAND, code 5 bit-wise NOR and code 6 bit-wise XNOR, per lane.
- R5: Code 7 gives (a + b) mod 4 per lane, with no carry into the next lane and no carry-out.
- R6: Code 8 gives (a * b) mod 4 per lane.
- R7: Codes 9 to 15 drive an all-zero result.
- R8: A lane's result depends only on that lane's operand digits and the code.
- R9: With the output register enabled (the default), the result for inputs present at a rising clock edge appears after that edge, and a low rst_n at an edge clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_i | input | 4 | Operation code |
| a_i | input | 2*LANES | Operand A digit vector |
| b_i | input | 2*LANES | Operand B digit vector |
| y_o | output | 2*LANES | Result digit vector |

## Verification
The assertions assume the operands and code are stable across the sampling edge and hold known values whenever reset is high, so that the registered result can be tied to the inputs captured one edge earlier. The stimulus keeps to this by changing inputs only on the falling clock edge and by leaving them at zero until reset is released. Every code, including the spare ones, is swept with all sixteen digit pairs in a single lane, then whole vectors with unrelated random digits in every lane exercise lane isolation.

// File: rtl/qdl_pkg.sv
// Shared constants for the quaternary lane unit.
// Assumes a digit is always two bits wide.
package qdl_pkg;
    localparam int DIG_W = 2;

    typedef enum logic [3:0] {
        OP_OR   = 4'd0,
        OP_AND  = 4'd1,
        OP_INV  = 4'd2,
        OP_XOR  = 4'd3,
        OP_NAND = 4'd4,
        OP_NOR  = 4'd5,
        OP_XNOR = 4'd6,
        OP_ADD4 = 4'd7,
        OP_MUL4 = 4'd8
    } qop_e;
endpackage

// File: rtl/qdl_gates.sv
// Bit-wise gate bank for one digit: every output bit uses only the
// same-position bits of the two operand pairs.
// Assumes nothing about operand values.
module qdl_gates
    import qdl_pkg::*;
(
    input  logic [DIG_W-1:0] a_i,
    input  logic [DIG_W-1:0] b_i,
    output logic [DIG_W-1:0] or_o,
    output logic [DIG_W-1:0] and_o,
    output logic [DIG_W-1:0] inv_o,
    output logic [DIG_W-1:0] xor_o,
    output logic [DIG_W-1:0] nand_o,
    output logic [DIG_W-1:0] nor_o,
    output logic [DIG_W-1:0] xnor_o
);
    // Form each gate result position by position.
    always_comb begin
        or_o   = a_i | b_i;
        and_o  = a_i & b_i;
        inv_o  = ~a_i;
        xor_o  = a_i ^ b_i;
        nand_o = ~(a_i & b_i);
        nor_o  = ~(a_i | b_i);
        xnor_o = ~(a_i ^ b_i);
    end
endmodule

// File: rtl/qdl_mod4.sv
// Carry-free modulo-4 sum and product of one digit pair, built from
// XOR/AND terms; the carry out of bit 1 is dropped by design.
// Assumes digit pairs are {high, low}.
module qdl_mod4
    import qdl_pkg::*;
(
    input  logic [DIG_W-1:0] a_i,
    input  logic [DIG_W-1:0] b_i,
    output logic [DIG_W-1:0] sum_o,
    output logic [DIG_W-1:0] prod_o
);
    logic a_lo, a_hi, b_lo, b_hi;

    // Split the pairs into named bits.
    always_comb begin
        a_lo = a_i[0];
        a_hi = a_i[1];
        b_lo = b_i[0];
        b_hi = b_i[1];
    end

    // Sum: low bit is the half-add, high bit folds in the low carry.
    always_comb begin
        sum_o[0] = a_lo ^ b_lo;
        sum_o[1] = (a_lo & b_lo) ^ (a_hi ^ b_hi);
    end

    // Product: high bit keeps only the cross terms, the 4's term vanishes.
    always_comb begin
        prod_o[0] = a_lo & b_lo;
        prod_o[1] = (a_lo & b_hi) ^ (a_hi & b_lo);
    end
endmodule

// File: rtl/qdl_lane.sv
// One digit lane: the gate bank and the modulo-4 unit run side by side
// and the operation code picks one result; spare codes give zero.
// Assumes op_i is any 4-bit value.
module qdl_lane
    import qdl_pkg::*;
(
    input  logic [3:0]       op_i,
    input  logic [DIG_W-1:0] a_i,
    input  logic [DIG_W-1:0] b_i,
    output logic [DIG_W-1:0] y_o
);
    logic [DIG_W-1:0] r_or, r_and, r_inv, r_xor, r_nand, r_nor, r_xnor;
    logic [DIG_W-1:0] r_sum, r_prod;

    qdl_gates u_gates (
        .a_i    (a_i),
        .b_i    (b_i),
        .or_o   (r_or),
        .and_o  (r_and),
        .inv_o  (r_inv),
        .xor_o  (r_xor),
        .nand_o (r_nand),
        .nor_o  (r_nor),
        .xnor_o (r_xnor)
    );

    qdl_mod4 u_mod4 (
        .a_i    (a_i),
        .b_i    (b_i),
        .sum_o  (r_sum),
        .prod_o (r_prod)
    );

    // Select the lane result by operation code.
    always_comb begin
        case (op_i)
            OP_OR:   y_o = r_or;
            OP_AND:  y_o = r_and;
            OP_INV:  y_o = r_inv;
            OP_XOR:  y_o = r_xor;
            OP_NAND: y_o = r_nand;
            OP_NOR:  y_o = r_nor;
            OP_XNOR: y_o = r_xnor;
            OP_ADD4: y_o = r_sum;
            OP_MUL4: y_o = r_prod;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/quad_lane_alu.sv
// Digit-parallel quaternary logic/arithmetic unit: LANES independent
// lanes share one operation code. REG_OUT=1 adds a result register
// with synchronous active-low reset; REG_OUT=0 leaves it combinational.
// Assumes inputs are stable around the clock edge when registered.
module quad_lane_alu
    import qdl_pkg::*;
#(
    parameter int LANES   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             op_i,
    input  logic [LANES*DIG_W-1:0] a_i,
    input  logic [LANES*DIG_W-1:0] b_i,
    output logic [LANES*DIG_W-1:0] y_o
);
    localparam int VEC_W = LANES * DIG_W;

    logic [VEC_W-1:0] lane_y;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        qdl_lane u_lane (
            .op_i (op_i),
            .a_i  (a_i[k*DIG_W +: DIG_W]),
            .b_i  (b_i[k*DIG_W +: DIG_W]),
            .y_o  (lane_y[k*DIG_W +: DIG_W])
        );
    end

    if (REG_OUT) begin : g_reg
        logic [VEC_W-1:0] y_q;
        // Capture the lane results, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) y_q <= '0;
            else        y_q <= lane_y;
        end
        assign y_o = y_q;
    end else begin : g_comb
        logic unused_ctl;
        assign unused_ctl = clk ^ rst_n;
        assign y_o = lane_y;
    end
endmodule

// File: rtl/qdl_checker.sv
// Property checker for quad_lane_alu, bound to every instance.
// It holds the inputs behind the optional output register so each
// result is compared with the inputs that produced it.
module qdl_checker
    import qdl_pkg::*;
#(
    parameter int LANES   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             op_i,
    input logic [LANES*DIG_W-1:0] a_i,
    input logic [LANES*DIG_W-1:0] b_i,
    input logic [LANES*DIG_W-1:0] y_o
);
    localparam int VEC_W = LANES * DIG_W;

    logic [3:0]       ref_op;
    logic [VEC_W-1:0] ref_a, ref_b;
    logic             vld;

    if (REG_OUT) begin : g_hold
        logic [3:0]       op_q;
        logic [VEC_W-1:0] a_q, b_q;
        logic             v_q;
        // Delay the inputs by the register's one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op_q <= '0; a_q <= '0; b_q <= '0; v_q <= 1'b0;
            end else begin
                op_q <= op_i; a_q <= a_i; b_q <= b_i; v_q <= 1'b1;
            end
        end
        assign ref_op = op_q;
        assign ref_a  = a_q;
        assign ref_b  = b_q;
        assign vld    = v_q;

        AST_RESET_CLEARS: assert property (@(posedge clk)
            !rst_n |=> y_o == '0); // R9
    end else begin : g_pass
        assign ref_op = op_i;
        assign ref_a  = a_i;
        assign ref_b  = b_i;
        assign vld    = rst_n;
    end

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vld && ref_op > 4'd8 |-> y_o == '0); // R7

    AST_INV_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        vld && ref_op == 4'd2 |-> y_o == ~ref_a); // R3

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        AST_ADD_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            vld && ref_op == 4'd7 |->
            y_o[k*DIG_W] == (ref_a[k*DIG_W] ^ ref_b[k*DIG_W])); // R5

        AST_ADD_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
            vld && ref_op == 4'd7 && ref_b[k*DIG_W +: DIG_W] == '0 |->
            y_o[k*DIG_W +: DIG_W] == ref_a[k*DIG_W +: DIG_W]); // R5

        AST_MUL_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            vld && ref_op == 4'd8 && ref_a[k*DIG_W +: DIG_W] == '0 |->
            y_o[k*DIG_W +: DIG_W] == '0); // R6
    end
endmodule

bind quad_lane_alu qdl_checker #(.LANES(LANES), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_quad_lane_alu.sv
// Scoreboard bench: the driver pushes expected results into a queue,
// the monitor pops one per cycle after the register updates.
module sim_quad_lane_alu;
    localparam int LANES = 8;
    localparam int VW    = 2 * LANES;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op_i = '0;
    logic [VW-1:0] a_i = '0, b_i = '0;
    logic [VW-1:0] y_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [VW-1:0] exp;
        string         tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk; // 50 MHz

    quad_lane_alu #(.LANES(LANES), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .y_o(y_o)
    );

    // Requirement-level model of one digit.
    function automatic logic [1:0] dig_model(input logic [3:0] op, input int a, input int b);
        logic [1:0] x, y;
        x = 2'(a); y = 2'(b);
        case (op)
            4'd0: return x | y;
            4'd1: return x & y;
            4'd2: return ~x;
            4'd3: return x ^ y;
            4'd4: return ~(x & y);
            4'd5: return ~(x | y);
            4'd6: return ~(x ^ y);
            4'd7: return 2'((a + b) % 4);
            4'd8: return 2'((a * b) % 4);
            default: return 2'b00;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd3: return "R2";
            4'd2:             return "R3";
            4'd4, 4'd5, 4'd6: return "R4";
            4'd7:             return "R5";
            4'd8:             return "R6";
            default:          return "R7";
        endcase
    endfunction

    function automatic logic [VW-1:0] vec_model(input logic [3:0] op,
                                                input logic [VW-1:0] a,
                                                input logic [VW-1:0] b);
        logic [VW-1:0] r;
        for (int k = 0; k < LANES; k++)
            r[2*k +: 2] = dig_model(op, int'(a[2*k +: 2]), int'(b[2*k +: 2]));
        return r;
    endfunction

    // Driver: apply inputs on the falling edge and queue the expectation.
    task automatic drive(input logic [3:0] op, input logic [VW-1:0] a,
                         input logic [VW-1:0] b, input string tag);
        item_t it;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        it.exp = vec_model(op, a, b);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic check(input logic [VW-1:0] act, input logic [VW-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: one result per cycle, sampled 2 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(y_o, it.exp, it.tag);
            end
        end
    end

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [VW-1:0] ra, rb, rb2;
        // R9: reset state.
        repeat (3) @(posedge clk);
        #2 check(y_o, '0, "R9 reset");
        @(negedge clk) rst_n = 1'b1;

        // R1: lane k holds digit (k mod 4); A=B so ADD doubles each digit.
        begin
            logic [VW-1:0] va, ve;
            for (int k = 0; k < LANES; k++) begin
                va[2*k +: 2] = 2'(k % 4);
                ve[2*k +: 2] = 2'((2 * (k % 4)) % 4);
            end
            drive(4'd7, va, va, "R1");
            drain();
            check(y_o, ve, "R1 lane placement");
        end

        // Exhaustive digit pairs in lane 0 for every code (R2..R7).
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    drive(4'(op), VW'(a), VW'(b), tag_of(4'(op)));
        drain();

        // R5: sum overflow in one lane must not reach its neighbour.
        drive(4'd7, 16'h000C, 16'h000C, "R5 no carry");
        drain();
        check(y_o, 16'h0008, "R5 lane1 3+3 isolated");

        // R3: B changes under code 2 do not move the result.
        ra = 16'hA5C3;
        drive(4'd2, ra, 16'h0000, "R3");
        drive(4'd2, ra, 16'hFFFF, "R3 B ignored");
        drain();
        check(y_o, ~ra, "R3 B ignored");

        // R8: random full vectors for every code.
        for (int n = 0; n < 300; n++) begin
            ra = VW'($urandom);
            rb = VW'($urandom);
            drive(4'(n % 16), ra, rb, "R8");
        end
        drain();

        // R8: altering lane 5 only leaves the other lanes unchanged.
        ra = 16'h6D2B; rb = 16'h93E1;
        rb2 = rb ^ 16'h0C00;
        drive(4'd8, ra, rb, "R8 base");
        drive(4'd8, ra, rb2, "R8 lane5 only");
        drain();

        // R9: reset mid-run clears a non-zero result.
        drive(4'd5, 16'h0000, 16'h0000, "R9 preload");
        drain();
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #2 check(y_o, '0, "R9 reset clears");
        @(negedge clk) rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule